// File: doc/BRIEF.md
# Unified Data Address Space Decoder

This block puts three storage regions behind a single word-addressed data port: a general-purpose RAM, a screen frame buffer and one read-only register that mirrors the keyboard. A client such as a processor drives a 15-bit address, 16-bit write data and a load strobe. The block sends the write to exactly one region and returns that region's read data on one 16-bit output.

The split is deliberately uneven. The lower half of the address space is RAM. The next quarter is the screen buffer. The single word just above the screen is the keyboard register, and every address above that is invalid. Reads are combinational from the current address. Writes take effect on the rising clock edge while load is high. The keyboard register captures the key-code input on every clock edge. It holds the code of the key being pressed, or 0 when no key is down.

Region storage is modelled as plain arrays. To keep elaboration small, the default parameters keep only the low address bits of each region. Setting the keep widths to 14 (RAM) and 13 (screen) gives full-size regions.

Top module: `mmap_decoder`

## Requirements
- R1: Addresses 0 to 16383 (address bit 14 = 0) access the RAM region: a word written there reads back unchanged at the same address.
- R2: Addresses 16384 to 24575 (bit 14 = 1, bit 13 = 0) access the screen region, indexed by address bits 12:0, and that storage is separate from the RAM (screen offset k does not alias RAM word k).
- R3: Address 24576 reads the keyboard register. The register takes the value of key_code at every rising clock edge and is 0 while reset is held.
- R4: Addresses 24577 to 32767 are invalid. Reading one returns 0 with addr_err = 1. Every valid address gives addr_err = 0.
- R5: A load to the keyboard address or to an invalid address changes no RAM word, no screen word and not the keyboard register.
- R6: A write happens only on a rising edge with load = 1. With load = 0 the stored words keep their values whatever the write data.
- R7: rdata and addr_err follow a change of address within the same cycle, with no clock edge needed.
- R8: With default parameters each region keeps only its low 11 index bits. RAM word 2048 is the same storage as RAM word 0, and screen offset 2048 is the same storage as screen offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset (clears the keyboard register) |
| addr | input | 15 | Word address into the unified space |
| wdata | input | 16 | Data to write |
| load | input | 1 | Write strobe, sampled at the rising edge |
| key_code | input | 16 | Code of the currently pressed key, 0 if none |
| rdata | output | 16 | Read data of the addressed word |
| addr_err | output | 1 | High while the address is invalid |

## Verification
A mistake in the region decode shows at once on rdata. A write lands in the wrong array, or in none, so the next read of that address returns stale or foreign data. Reads of the neighbouring region reveal the same overlap. A bad keyboard register shows one edge after key_code changes. The checks therefore read the keyboard word in the cycle right after the edge, and they probe adjacent boundary addresses right after every write.

// File: rtl/mmap_decoder.sv
module mmap_decoder #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 16,
  parameter int RAM_KEEP_AW = 11,
  parameter int SCR_KEEP_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic [DATA_W-1:0] key_code,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_err
);
  localparam int SCR_AW    = ADDR_W - 2;
  localparam int RAM_DEPTH = 1 << RAM_KEEP_AW;
  localparam int SCR_DEPTH = 1 << SCR_KEEP_AW;

  logic [DATA_W-1:0] ram [RAM_DEPTH];
  logic [DATA_W-1:0] scr [SCR_DEPTH];
  logic [DATA_W-1:0] kbd_q;

  logic ram_sel, scr_sel, kbd_sel;
  logic [RAM_KEEP_AW-1:0] ram_idx;
  logic [SCR_KEEP_AW-1:0] scr_idx;

  assign ram_sel  = ~addr[ADDR_W-1];
  assign scr_sel  = addr[ADDR_W-1] & ~addr[ADDR_W-2];
  assign kbd_sel  = addr[ADDR_W-1] & addr[ADDR_W-2] & ~|addr[SCR_AW-1:0];
  assign addr_err = ~(ram_sel | scr_sel | kbd_sel);
  assign ram_idx  = addr[RAM_KEEP_AW-1:0];
  assign scr_idx  = addr[SCR_KEEP_AW-1:0];

  always_ff @(posedge clk) begin
    if (load && ram_sel) ram[ram_idx] <= wdata;
    if (load && scr_sel) scr[scr_idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kbd_q <= '0;
    else        kbd_q <= key_code;
  end

  always_comb begin
    rdata = '0;
    if (ram_sel)      rdata = ram[ram_idx];
    else if (scr_sel) rdata = scr[scr_idx];
    else if (kbd_sel) rdata = kbd_q;
  end
endmodule

module mmap_decoder_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              load,
  input logic [DATA_W-1:0] key_code,
  input logic [DATA_W-1:0] rdata,
  input logic              addr_err,
  input logic              ram_sel,
  input logic              scr_sel,
  input logic              kbd_sel
);
  assert_one_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_sel, scr_sel, kbd_sel, addr_err}) == 1);

  assert_invalid_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> rdata == '0);

  assert_kbd_follows_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_sel && $past(rst_n)) |-> rdata == $past(key_code));

  assert_ram_writeback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ram_sel) |=> (addr != $past(addr) || rdata == $past(wdata)));

  assert_scr_writeback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && scr_sel) |=> (addr != $past(addr) || rdata == $past(wdata)));

  assert_hold_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (ram_sel || scr_sel)) |=> (addr != $past(addr) || $stable(rdata)));
endmodule

bind mmap_decoder mmap_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .load(load),
  .key_code(key_code), .rdata(rdata), .addr_err(addr_err),
  .ram_sel(ram_sel), .scr_sel(scr_sel), .kbd_sel(kbd_sel)
);

// File: tb/sim_mmap_decoder.sv
`timescale 1ns/1ps
module sim_mmap_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        load = 0;
  logic [15:0] key_code = '0;
  logic [15:0] rdata;
  logic        addr_err;
  int total = 0, bad = 0;

  mmap_decoder u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .load(load),
                   .key_code(key_code), .rdata(rdata), .addr_err(addr_err));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic rd(input logic [14:0] a, input string req, input logic [15:0] exp);
    addr = a; #0.5;
    check(req, rdata, exp);
  endtask

  task automatic t_reset;
    rd(15'd24576, "R3 reset value", 16'h0000);
    check("R4 err low on kbd", {15'b0, addr_err}, 16'd0);
  endtask

  task automatic t_ram;
    wr(15'd0, 16'hA001); wr(15'd1, 16'hA002); wr(15'd16383, 16'hBEEF);
    rd(15'd0, "R1 ram 0", 16'hA001);
    rd(15'd1, "R1 ram 1", 16'hA002);
    rd(15'd16383, "R1 ram top", 16'hBEEF);
  endtask

  task automatic t_screen;
    wr(15'd16384, 16'h5C00); wr(15'd24575, 16'h5CFF);
    rd(15'd16384, "R2 screen base", 16'h5C00);
    rd(15'd24575, "R2 screen top", 16'h5CFF);
    rd(15'd0, "R2 ram not aliased", 16'hA001);
    check("R2 err low", {15'b0, addr_err}, 16'd0);
  endtask

  task automatic t_keyboard;
    @(negedge clk); key_code = 16'h0041; addr = 15'd24576;
    #0.5 check("R3 before edge", rdata, 16'h0000);
    @(negedge clk); #0.5 check("R3 after edge", rdata, 16'h0041);
    key_code = 16'h0000;
    @(negedge clk); #0.5 check("R3 key released", rdata, 16'h0000);
  endtask

  task automatic t_invalid;
    rd(15'd24577, "R4 invalid low rdata", 16'h0000);
    check("R4 invalid low err", {15'b0, addr_err}, 16'd1);
    rd(15'd32767, "R4 invalid top rdata", 16'h0000);
    check("R4 invalid top err", {15'b0, addr_err}, 16'd1);
  endtask

  task automatic t_ignored;
    wr(15'd16385, 16'h1111);
    key_code = 16'h0077;
    wr(15'd24576, 16'hDEAD);
    rd(15'd24576, "R5 kbd write ignored", 16'h0077);
    wr(15'd24577, 16'hDEAD);
    rd(15'd1, "R5 invalid write ram", 16'hA002);
    rd(15'd16385, "R5 invalid write screen", 16'h1111);
    rd(15'd24576, "R5 invalid write kbd", 16'h0077);
  endtask

  task automatic t_hold;
    @(negedge clk); addr = 15'd1; wdata = 16'hFFFF; load = 0;
    @(negedge clk); @(negedge clk);
    #0.5 check("R6 ram held without load", rdata, 16'hA002);
    addr = 15'd16384; #0.5 check("R6 screen held", rdata, 16'h5C00);
  endtask

  task automatic t_comb;
    @(negedge clk);
    addr = 15'd0; #0.2 check("R7 comb ram", rdata, 16'hA001);
    addr = 15'd16384; #0.2 check("R7 comb screen", rdata, 16'h5C00);
    addr = 15'd30000; #0.2 check("R7 comb err", {15'b0, addr_err}, 16'd1);
  endtask

  task automatic t_alias;
    wr(15'd2048, 16'h2048);
    rd(15'd0, "R8 ram alias", 16'h2048);
    wr(15'd16384 + 15'd2048, 16'h3048);
    rd(15'd16384, "R8 screen alias", 16'h3048);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #0.5 t_reset();
        rst_n = 1;
        t_ram(); t_screen(); t_keyboard(); t_invalid();
        t_ignored(); t_hold(); t_comb(); t_alias();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule